// File: doc/BRIEF.md
# Virtual Calibration Window Access Filter

This block sits on the data bus behind the address-overlay unit and judges every access that targets a 32 KB calibration window with no physical storage behind it. The window can be reached through two address aliases, one cached and one non-cached. An access that the overlay unit has already redirected to a real overlay block is left alone. An access that reaches the window unredirected is either silently discarded or flagged as a bus error.

A write is discarded quietly only when three conditions hold: a global enable is set, the access uses the non-cached attribute, and the overlay unit did not redirect it. Every other unredirected access to the window is flagged as a bus error. This covers reads, writes with the cached attribute, and any access made while the enable is clear. The verdict appears on two registered outputs in the cycle after the access strobe.

Top module: `calwin_access_filter`

## Requirements
- R1: An address is inside the window when bits [31:15] match `WIN_BASE` (default 32'hAFE7_0000), with bit 29 (the alias bit) not compared. Offsets 0x0000 to 0x7FFF in both aliases (0xAFE7_xxxx and 0x8FE7_xxxx) are therefore inside.
- R2: An access whose address lies outside the window never raises `drop_o` or `berr_o`.
- R3: An unredirected write inside the window, made with `feat_en_i`=1 and `acc_cached_i`=0, gives `drop_o`=1 and `berr_o`=0.
- R4: An unredirected write inside the window made with `acc_cached_i`=1 gives `berr_o`=1 and `drop_o`=0, whatever `feat_en_i` is.
- R5: An unredirected read inside the window gives `berr_o`=1 and `drop_o`=0 in every combination of enable and attribute.
- R6: An access with `redir_i`=1 gives `drop_o`=0 and `berr_o`=0 in all cases.
- R7: With `feat_en_i`=0, every unredirected access inside the window gives `berr_o`=1.
- R8: The outputs reflect the access presented with `acc_valid_i`=1 on the previous rising edge. They are both 0 after a cycle with no valid access, and they are never 1 together.
- R9: While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Access strobe |
| acc_addr_i | input | 32 | Access address after overlay |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_cached_i | input | 1 | 1 = cached attribute |
| redir_i | input | 1 | Access was redirected to a real overlay block |
| feat_en_i | input | 1 | Global write-discard enable |
| drop_o | output | 1 | Access is to be discarded silently |
| berr_o | output | 1 | Access is to raise a bus error |

## Verification
The bench sweeps every combination of direction, attribute, redirect and enable over addresses at both ends of the window in both aliases, and just outside each end. A decoder that compared the alias bit would fault or discard nothing in the cached alias. A decoder that was one bit too wide or too narrow would misjudge offsets 0x7FFF or 0x8000. The sweep also catches any mix-up in which condition wins. If the attribute check were dropped, cached writes would be discarded instead of faulting. If the enable were ignored, writes would be discarded while the feature is off. If the redirect qualifier were missing, legitimate overlay traffic would fault.

// File: rtl/calwin_pkg.sv
package calwin_pkg;
  typedef enum logic [1:0] {
    VERDICT_PASS = 2'b00,
    VERDICT_DROP = 2'b01,
    VERDICT_BERR = 2'b10
  } verdict_e;
endpackage

// File: rtl/calwin_decode.sv
module calwin_decode #(
  parameter int          ADDR_W    = 32,
  parameter int          OFS_W     = 15,
  parameter int          ALIAS_BIT = 29,
  parameter logic [31:0] WIN_BASE  = 32'hAFE7_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_win_o
);
  localparam logic [ADDR_W-1:0] OFS_MASK   = ADDR_W'((64'd1 << OFS_W) - 64'd1);
  localparam logic [ADDR_W-1:0] ALIAS_MASK = ADDR_W'(64'd1 << ALIAS_BIT);
  localparam logic [ADDR_W-1:0] CMP_MASK   = ~(OFS_MASK | ALIAS_MASK);
  localparam logic [ADDR_W-1:0] BASE       = WIN_BASE[ADDR_W-1:0];

  always_comb begin
    in_win_o = (((addr_i ^ BASE) & CMP_MASK) == '0);
  end
endmodule

// File: rtl/calwin_rules.sv
module calwin_rules
  import calwin_pkg::*;
(
  input  logic     in_win_i,
  input  logic     write_i,
  input  logic     cached_i,
  input  logic     redir_i,
  input  logic     feat_en_i,
  output verdict_e verdict_o
);
  always_comb begin
    verdict_o = VERDICT_PASS;
    if (in_win_i && !redir_i) begin
      if (write_i && feat_en_i && !cached_i) verdict_o = VERDICT_DROP;
      else                                   verdict_o = VERDICT_BERR;
    end
  end
endmodule

// File: rtl/calwin_outreg.sv
module calwin_outreg
  import calwin_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     valid_i,
  input  verdict_e verdict_i,
  output logic     drop_o,
  output logic     berr_o
);
  logic drop_d, berr_d, drop_q, berr_q;
  logic upd_en;

  always_comb begin
    upd_en = 1'b1;
    drop_d = valid_i && (verdict_i == VERDICT_DROP);
    berr_d = valid_i && (verdict_i == VERDICT_BERR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q <= 1'b0;
      berr_q <= 1'b0;
    end else if (upd_en) begin
      drop_q <= drop_d;
      berr_q <= berr_d;
    end
  end

  assign drop_o = drop_q;
  assign berr_o = berr_q;
endmodule

// File: rtl/calwin_access_filter.sv
module calwin_access_filter
  import calwin_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          OFS_W     = 15,
  parameter int          ALIAS_BIT = 29,
  parameter logic [31:0] WIN_BASE  = 32'hAFE7_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic              acc_cached_i,
  input  logic              redir_i,
  input  logic              feat_en_i,
  output logic              drop_o,
  output logic              berr_o
);
  logic     in_win;
  verdict_e verdict;

  calwin_decode #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .ALIAS_BIT(ALIAS_BIT), .WIN_BASE(WIN_BASE)
  ) u_decode (
    .addr_i   (acc_addr_i),
    .in_win_o (in_win)
  );

  calwin_rules u_rules (
    .in_win_i  (in_win),
    .write_i   (acc_write_i),
    .cached_i  (acc_cached_i),
    .redir_i   (redir_i),
    .feat_en_i (feat_en_i),
    .verdict_o (verdict)
  );

  calwin_outreg u_outreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (acc_valid_i),
    .verdict_i (verdict),
    .drop_o    (drop_o),
    .berr_o    (berr_o)
  );
endmodule

// File: rtl/calwin_access_filter_chk.sv
module calwin_access_filter_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              acc_write_i,
  input logic              acc_cached_i,
  input logic              redir_i,
  input logic              feat_en_i,
  input logic              in_win,
  input logic              drop_o,
  input logic              berr_o
);
  // R8: the two verdicts never coincide
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(drop_o && berr_o));

  // R8: no access strobe, no verdict in the following cycle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_i |=> (!drop_o && !berr_o));

  // R6: redirected traffic passes
  p_redir_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && redir_i) |=> (!drop_o && !berr_o));

  // R2: outside the window nothing is flagged
  p_outside_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !in_win) |=> (!drop_o && !berr_o));

  // R5: unredirected reads in the window fault
  p_read_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && in_win && !redir_i && !acc_write_i) |=> berr_o);

  // R3: a discard only follows an enabled, non-cached, unredirected write
  p_drop_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |-> $past(acc_valid_i && acc_write_i && !acc_cached_i && feat_en_i && !redir_i));

  // R7: with the enable clear, unredirected window accesses fault
  p_disabled_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && in_win && !redir_i && !feat_en_i) |=> berr_o);
endmodule

bind calwin_access_filter calwin_access_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid_i  (acc_valid_i),
  .acc_addr_i   (acc_addr_i),
  .acc_write_i  (acc_write_i),
  .acc_cached_i (acc_cached_i),
  .redir_i      (redir_i),
  .feat_en_i    (feat_en_i),
  .in_win       (in_win),
  .drop_o       (drop_o),
  .berr_o       (berr_o)
);

// File: tb/test_calwin_access_filter.sv
`timescale 1ns/1ps
module test_calwin_access_filter;
  logic        clk;
  logic        rst_n;
  logic        acc_valid_i;
  logic [31:0] acc_addr_i;
  logic        acc_write_i;
  logic        acc_cached_i;
  logic        redir_i;
  logic        feat_en_i;
  logic        drop_o;
  logic        berr_o;

  int n_vec;
  int n_bad;
  bit done;

  calwin_access_filter i_calwin_access_filter (
    .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i),
    .acc_write_i(acc_write_i), .acc_cached_i(acc_cached_i), .redir_i(redir_i),
    .feat_en_i(feat_en_i), .drop_o(drop_o), .berr_o(berr_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic exp_drop, input logic exp_berr);
    n_vec++;
    if (drop_o !== exp_drop || berr_o !== exp_berr) begin
      n_bad++;
      $display("FAIL %s addr=%h w=%0b c=%0b r=%0b en=%0b: drop/berr=%0b%0b expected %0b%0b",
               req, acc_addr_i, acc_write_i, acc_cached_i, redir_i, feat_en_i,
               drop_o, berr_o, exp_drop, exp_berr);
    end
  endtask

  // Drive at a falling edge, let one rising edge register it, sample at the next falling edge.
  task automatic apply(input logic [31:0] a, input logic w, input logic c,
                       input logic r, input logic en);
    logic inwin, ed, eb;
    string req;
    @(negedge clk);
    acc_valid_i = 1'b1; acc_addr_i = a; acc_write_i = w;
    acc_cached_i = c; redir_i = r; feat_en_i = en;
    inwin = ((a & 32'hDFFF_8000) == 32'h8FE7_0000); // R1
    ed = 1'b0; eb = 1'b0;
    if (!inwin)     req = "R2";
    else if (r)     req = "R6";
    else if (!en)   begin eb = 1'b1; req = "R7"; end
    else if (!w)    begin eb = 1'b1; req = "R5"; end
    else if (c)     begin eb = 1'b1; req = "R4"; end
    else            begin ed = 1'b1; req = "R3"; end
    if (inwin) req = {req, "/R1"};
    @(negedge clk);
    check(req, ed, eb);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] addrs [10];
    n_vec = 0; n_bad = 0; done = 1'b0;
    addrs = '{32'hAFE7_0000, 32'hAFE7_7FFF, 32'h8FE7_0000, 32'h8FE7_7FFF,
              32'hAFE7_4321, 32'hAFE7_8000, 32'hAFE6_FFFF, 32'h8FE7_8000,
              32'h0FE7_0000, 32'h1234_5678};
    rst_n = 1'b0; acc_valid_i = 1'b1; acc_addr_i = 32'hAFE7_0000;
    acc_write_i = 1'b0; acc_cached_i = 1'b0; redir_i = 1'b0; feat_en_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", 1'b0, 1'b0);
    rst_n = 1'b1;
    acc_valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8", 1'b0, 1'b0);

    for (int i = 0; i < 10; i++)
      for (int k = 0; k < 16; k++)
        apply(addrs[i], k[0], k[1], k[2], k[3]);

    // R8: strobe low on an access that would fault gives no verdict
    @(negedge clk);
    acc_valid_i = 1'b0; acc_addr_i = 32'hAFE7_0010; acc_write_i = 1'b0;
    redir_i = 1'b0; feat_en_i = 1'b0;
    @(negedge clk);
    check("R8", 1'b0, 1'b0);
    // R8: strobe low on a write that would be discarded
    acc_write_i = 1'b1; feat_en_i = 1'b1; acc_cached_i = 1'b0;
    @(negedge clk);
    check("R8", 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule